// File: doc/BRIEF.md
# Deserializer output drive-state controller

This block decides, once per clock, how each group of a deserializer's parallel output pads is driven: the clock output, the data and control outputs, the link-status output and the self-test result output. From the power enable, the clock-recovery lock flag, a select that picks between high-impedance and driven-low parking, and a 3-bit fallback-oscillator code, it produces registered output enables and source selects for the pad drivers. The pad drivers, clock recovery and the oscillator are outside the block.

The block also implements a hold-low mode. When the mode is strapped on, every output except the link-status pin is parked low from power-up and after every loss of lock. The outputs are released only when software raises a release bit while the link is locked. When the clock output moves between the recovered clock and the fallback oscillator, one cycle of a hold-level select keeps the pin quiet through the change.

Top module: `lock_output_ctrl`

## Requirements
- R1: While `pwr_en` is low, every output enable (`clk_oe`, `data_oe`, `lock_oe`, `pass_oe`) is 0. All value outputs are 0 and `clk_sel` is 00.
- R2: Powered and unlocked, with `osc_code` = 000, `hiz_sel` = 0 and hold-low inactive: all four groups are enabled and driven low. This means `clk_sel` = 00, `data_pass` = 0, `lock_val` = 0 and `pass_val` = 0.
- R3: Powered and unlocked, with `osc_code` = 000, `hiz_sel` = 1 and hold-low inactive: `clk_oe` = 0 and `data_oe` = 0, while `lock_oe` = 1, `pass_oe` = 1, `lock_val` = 0 and `pass_val` = 0.
- R4: Powered and locked, with hold-low inactive: `clk_sel` = 01 (recovered clock), `data_pass` = 1, and `lock_val` and `pass_val` are both 1, with all enables at 1.
- R5: Powered and unlocked, with `osc_code` ≠ 000 and hold-low inactive: `clk_sel` = 10 (oscillator), the data are driven low, `lock_val` = 0 and `pass_val` = 1.
- R6: `osc_en` is 1 exactly when powered with `osc_code` ≠ 000. `osc_div` gives the divider of the base oscillator: 0 for code 0, the code itself for codes 1 to 6, and 8 for code 7.
- R7: Hold-low is active when `hold_strap` = 1 and the armed flag is set. While active, and while powered, the clock, data and pass outputs are enabled and driven low (`clk_sel` = 00). The link-status output still follows R4/R5.
- R8: A rising edge of `hold_release` disarms hold-low only while `link_locked` = 1. An edge while unlocked is ignored.
- R9: The armed flag is set by reset, by power-down and by a falling edge of `link_locked`. A `hold_rearm` pulse also sets it, but only while locked. When release and rearm arrive together, rearm wins.
- R10: When the clock source changes directly between recovered (01) and oscillator (10), `clk_sel` shows 11 (hold level) for one cycle before the new source.
- R11: All outputs are registered. After reset every enable is 0, and an input change appears on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable; low means powered down |
| link_locked | input | 1 | Lock flag from clock recovery |
| hiz_sel | input | 1 | Unlocked parking: 0 drive low, 1 high-impedance |
| osc_code | input | 3 | Fallback oscillator code; 000 disables it |
| hold_strap | input | 1 | Enables the hold-low mode |
| hold_release | input | 1 | Release bit; rising edge while locked disarms |
| hold_rearm | input | 1 | Manual rearm pulse, honoured while locked |
| clk_oe | output | 1 | Clock output pad enable |
| clk_sel | output | 2 | Clock source: 00 low, 01 recovered, 10 oscillator, 11 hold level |
| data_oe | output | 1 | Data/control pad enable |
| data_pass | output | 1 | 1 passes recovered data, 0 drives low |
| lock_oe | output | 1 | Link-status pad enable |
| lock_val | output | 1 | Link-status value |
| pass_oe | output | 1 | Test-result pad enable |
| pass_val | output | 1 | Test-result value |
| osc_en | output | 1 | Oscillator run request |
| osc_div | output | 4 | Oscillator divider |

## Verification
The stimulus first walks through the unlocked parking cases: powered down, driven-low parking, high-impedance parking, and each of the seven oscillator codes. These separate the priority of power-down over parking, and parking over the oscillator fallback. Lock is then toggled with the oscillator on and with it off. This shows whether the one-cycle hold-level select appears only on a direct recovered-to-oscillator change.

With hold-low strapped, release edges are applied while unlocked and then while locked, followed by lock loss and by manual rearm pulses in both lock states. These tell the automatic rearm apart from the manual one, and an honoured release from an ignored one. A reference model checks every output on every cycle.

// File: rtl/lock_output_ctrl.sv
module lock_output_ctrl #(
  parameter int CODE_W = 3,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              link_locked,
  input  logic              hiz_sel,
  input  logic [CODE_W-1:0] osc_code,
  input  logic              hold_strap,
  input  logic              hold_release,
  input  logic              hold_rearm,
  output logic              clk_oe,
  output logic [1:0]        clk_sel,
  output logic              data_oe,
  output logic              data_pass,
  output logic              lock_oe,
  output logic              lock_val,
  output logic              pass_oe,
  output logic              pass_val,
  output logic              osc_en,
  output logic [DIV_W-1:0]  osc_div
);
  localparam logic [1:0] CK_LOW = 2'd0, CK_REC = 2'd1, CK_OSC = 2'd2, CK_HOLD = 2'd3;
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  logic lock_q, rel_q, armed_q, armed_d;
  logic held, osc_on;
  logic [1:0] ck_tgt, ck_nxt;
  logic [DIV_W-1:0] div_d;

  wire lock_fall = lock_q & ~link_locked;
  wire rel_rise  = hold_release & ~rel_q;

  always_comb begin
    armed_d = armed_q;
    if (!pwr_en || lock_fall)                armed_d = 1'b1;
    else if (link_locked && hold_rearm)      armed_d = 1'b1;
    else if (link_locked && rel_rise)        armed_d = 1'b0;
  end

  assign held   = pwr_en & hold_strap & armed_d;
  assign osc_on = pwr_en & (osc_code != '0);
  assign div_d  = !osc_on ? '0 :
                  (osc_code == CODE_TOP) ? DIV_W'(2 ** CODE_W) : DIV_W'(osc_code);

  always_comb begin
    if (!pwr_en || held)  ck_tgt = CK_LOW;
    else if (link_locked) ck_tgt = CK_REC;
    else if (osc_on)      ck_tgt = CK_OSC;
    else                  ck_tgt = CK_LOW;
    if ((clk_sel == CK_REC && ck_tgt == CK_OSC) || (clk_sel == CK_OSC && ck_tgt == CK_REC))
      ck_nxt = CK_HOLD;
    else
      ck_nxt = ck_tgt;
  end

  wire park_hiz = !link_locked && !osc_on && hiz_sel && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      rel_q     <= 1'b0;
      armed_q   <= 1'b1;
      clk_oe    <= 1'b0;
      clk_sel   <= CK_LOW;
      data_oe   <= 1'b0;
      data_pass <= 1'b0;
      lock_oe   <= 1'b0;
      lock_val  <= 1'b0;
      pass_oe   <= 1'b0;
      pass_val  <= 1'b0;
      osc_en    <= 1'b0;
      osc_div   <= '0;
    end else begin
      lock_q    <= link_locked;
      rel_q     <= hold_release;
      armed_q   <= armed_d;
      clk_sel   <= ck_nxt;
      clk_oe    <= pwr_en && !park_hiz;
      data_oe   <= pwr_en && !park_hiz;
      data_pass <= pwr_en && link_locked && !held;
      lock_oe   <= pwr_en;
      lock_val  <= pwr_en && link_locked;
      pass_oe   <= pwr_en;
      pass_val  <= pwr_en && !held && (link_locked || osc_on);
      osc_en    <= osc_on;
      osc_div   <= div_d;
    end
  end
endmodule

module lock_output_ctrl_chk #(
  parameter int CODE_W = 3,
  parameter int DIV_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_en,
  input logic              link_locked,
  input logic              hiz_sel,
  input logic [CODE_W-1:0] osc_code,
  input logic              hold_strap,
  input logic              hold_release,
  input logic              hold_rearm,
  input logic              clk_oe,
  input logic [1:0]        clk_sel,
  input logic              data_oe,
  input logic              data_pass,
  input logic              lock_oe,
  input logic              lock_val,
  input logic              pass_oe,
  input logic              pass_val,
  input logic              osc_en,
  input logic [DIV_W-1:0]  osc_div
);
  p_off_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !clk_oe && !data_oe && !lock_oe && !pass_oe);

  p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && link_locked) |=> lock_oe && lock_val);

  p_osc_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !link_locked && osc_code != '0 && !hold_strap)
      |=> pass_val && !lock_val && data_oe && !data_pass);

  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && hold_strap && !link_locked) |=> !data_pass && !pass_val && clk_sel == 2'd0);

  p_no_direct_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd1 || clk_sel == 2'd2) |=> $countones(clk_sel ^ $past(clk_sel)) != 2 || clk_sel == 2'd0);

  p_osc_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && osc_code != '0) |=> osc_en && osc_div != '0);
endmodule

bind lock_output_ctrl lock_output_ctrl_chk #(.CODE_W(CODE_W), .DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_lock_output_ctrl.sv
module test_lock_output_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0, link_locked = 1'b0, hiz_sel = 1'b0;
  logic [2:0] osc_code = 3'd0;
  logic hold_strap = 1'b0, hold_release = 1'b0, hold_rearm = 1'b0;
  logic clk_oe, data_oe, data_pass, lock_oe, lock_val, pass_oe, pass_val, osc_en;
  logic [1:0] clk_sel;
  logic [3:0] osc_div;

  always #2 clk = ~clk;

  lock_output_ctrl i_lock_output_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit m_lock_prev, m_rel_prev, m_armed;
  int m_src;
  bit e_clk_oe, e_data_oe, e_data_pass, e_lock_oe, e_lock_val, e_pass_oe, e_pass_val, e_osc_en;
  logic [1:0] e_clk_sel;
  logic [3:0] e_osc_div;
  string m_tag;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock_prev = 0; m_rel_prev = 0; m_armed = 1; m_src = 0;
      {e_clk_oe, e_data_oe, e_data_pass, e_lock_oe, e_lock_val, e_pass_oe, e_pass_val, e_osc_en} = '0;
      e_clk_sel = 0; e_osc_div = 0; m_tag = "R11";
    end else begin
      bit hold_on, osc_on;
      int want;
      if (!pwr_en) m_armed = 1;
      else if (m_lock_prev && !link_locked) m_armed = 1;
      else if (link_locked && hold_rearm) m_armed = 1;
      else if (link_locked && hold_release && !m_rel_prev) m_armed = 0;
      m_lock_prev = link_locked; m_rel_prev = hold_release;
      hold_on = pwr_en && hold_strap && m_armed;
      osc_on = pwr_en && osc_code != 0;
      e_osc_en = osc_on;
      case (osc_code)
        3'd7: e_osc_div = 8;
        default: e_osc_div = 4'(osc_code);
      endcase
      if (!osc_on) e_osc_div = 0;
      if (!pwr_en) begin
        m_tag = "R1"; want = 0;
        {e_clk_oe, e_data_oe, e_data_pass, e_lock_oe, e_lock_val, e_pass_oe, e_pass_val} = '0;
      end else begin
        e_lock_oe = 1; e_pass_oe = 1; e_lock_val = link_locked;
        e_clk_oe = 1; e_data_oe = 1;
        if (hold_on) begin
          m_tag = "R7"; want = 0; e_data_pass = 0; e_pass_val = 0;
        end else if (link_locked) begin
          m_tag = "R4"; want = 1; e_data_pass = 1; e_pass_val = 1;
        end else if (osc_on) begin
          m_tag = "R5"; want = 2; e_data_pass = 0; e_pass_val = 1;
        end else begin
          want = 0; e_data_pass = 0; e_pass_val = 0;
          if (hiz_sel) begin m_tag = "R3"; e_clk_oe = 0; e_data_oe = 0; end
          else m_tag = "R2";
        end
      end
      if ((m_src == 1 && want == 2) || (m_src == 2 && want == 1)) begin
        m_src = 3; m_tag = "R10";
      end else m_src = want;
      e_clk_sel = 2'(m_src);
    end
    #1;
    check({clk_oe, clk_sel, data_oe, data_pass, lock_oe, lock_val, pass_oe, pass_val, osc_en, osc_div} ===
          {e_clk_oe, e_clk_sel, e_data_oe, e_data_pass, e_lock_oe, e_lock_val, e_pass_oe, e_pass_val, e_osc_en, e_osc_div},
          m_tag, "outputs",
          int'({clk_oe, clk_sel, data_oe, data_pass, lock_oe, lock_val, pass_oe, pass_val, osc_en, osc_div}),
          int'({e_clk_oe, e_clk_sel, e_data_oe, e_data_pass, e_lock_oe, e_lock_val, e_pass_oe, e_pass_val, e_osc_en, e_osc_div}));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    finish_run();
  end

  initial begin
    cyc(3);
    check(!clk_oe && !data_oe && !lock_oe && !pass_oe, "R11", "reset enables", int'(clk_oe), 0);
    rst_n = 1; cyc(3);
    check(!lock_oe, "R1", "powered down lock_oe", int'(lock_oe), 0);
    pwr_en = 1; cyc(1);
    @(posedge clk); #1 check(clk_oe && clk_sel == 0 && lock_oe, "R11", "one-edge latency", int'(clk_oe), 1);
    cyc(2);
    check(clk_oe && clk_sel == 0 && !lock_val && !pass_val, "R2", "driven-low park", int'(clk_sel), 0);
    hiz_sel = 1; cyc(3);
    check(!clk_oe && !data_oe && pass_oe, "R3", "hiz park", int'(clk_oe), 0);
    for (int c = 1; c < 8; c++) begin
      osc_code = 3'(c); cyc(2);
      check(osc_div == ((c == 7) ? 8 : c), "R6", "divider", int'(osc_div), (c == 7) ? 8 : c);
    end
    check(clk_sel == 2 && pass_val && !lock_val, "R5", "oscillator fallback", int'(clk_sel), 2);
    link_locked = 1; @(negedge clk);
    check(clk_sel == 3, "R10", "hold on osc to rec", int'(clk_sel), 3);
    cyc(1);
    check(clk_sel == 1 && data_pass && lock_val, "R4", "locked", int'(clk_sel), 1);
    link_locked = 0; cyc(3);
    osc_code = 0; hiz_sel = 0; cyc(1); link_locked = 1; cyc(3); link_locked = 0; cyc(3);
    // hold-low
    osc_code = 3'd2; hold_strap = 1; cyc(3);
    hold_release = 1; cyc(2); hold_release = 0; cyc(1);
    link_locked = 1; cyc(3);
    check(!data_pass && clk_sel == 0 && lock_val, "R8", "release while unlocked ignored", int'(data_pass), 0);
    hold_release = 1; cyc(2);
    check(data_pass && clk_sel == 1, "R8", "release while locked", int'(data_pass), 1);
    hold_release = 0; cyc(2);
    link_locked = 0; cyc(2); link_locked = 1; cyc(3);
    check(!data_pass && !pass_val, "R9", "rearm on lock fall", int'(data_pass), 0);
    hold_release = 1; cyc(2); hold_release = 0; cyc(2);
    hold_rearm = 1; cyc(1); hold_rearm = 0; cyc(2);
    check(!data_pass && clk_sel == 0, "R9", "manual rearm", int'(data_pass), 0);
    hold_release = 1; hold_rearm = 1; cyc(1); hold_rearm = 0; cyc(2);
    check(!data_pass, "R9", "rearm wins over release", int'(data_pass), 0);
    hold_release = 0; cyc(1); hold_release = 1; cyc(2); hold_release = 0;
    check(data_pass, "R7", "released outputs pass", int'(data_pass), 1);
    pwr_en = 0; cyc(3);
    check(!clk_oe && !pass_oe && !data_oe, "R1", "power down from locked", int'(pass_oe), 0);
    pwr_en = 1; cyc(3);
    check(!data_pass && lock_val, "R9", "rearm on power down", int'(data_pass), 0);
    hold_strap = 0; link_locked = 0; cyc(4);
    finish_run();
  end
endmodule